// File: doc/BRIEF.md
# Indirect Register Access Window

This bridge lets a host that sees only a 256-byte register window reach every longword of a 512 KB internal register space. The window holds two special longwords: a pointer register that the host loads with a target address, and a data port. A read or write of the data port is carried out on the internal register bus at the pointer's address plus a fixed internal base offset. The sum wraps within the 19-bit internal address space.

Every other longword of the window is passed straight through to the same offset at the bottom of the internal space. Any access that uses the internal bus stalls the host with a wait flag until the internal side acknowledges. Read data comes back in the same host access that asked for it. Pointer accesses complete locally in one cycle.

The host holds `host_req` and its qualifiers steady until it sees the one-cycle `host_ack`, then drops the request.

Top module: `ind_win_bridge`

## Requirements
- R1: After reset `host_ack`, `host_wait` and `int_req` are low, and the pointer register reads back as 0.
- R2: A write to window offset 0x60 loads the pointer from host data bits 18:2. A read of offset 0x60 returns the pointer, with bits 1:0 and bits 31:19 zero.
- R3: A write to the data port at offset 0x64 issues one internal write. Its address is (pointer + base) with bits 1:0 zero, and it carries the host's write data unchanged.
- R4: A read of the data port issues one internal read. The `int_rdata` captured at `int_ack` is presented on `host_rdata` in the cycle where `host_ack` is high.
- R5: During an internal access `host_wait` is high from the cycle after the request until `host_ack`. For an acknowledge latency of L idle cycles, the host sees L+1 wait cycles. `int_req`, `int_addr`, `int_we` and `int_wdata` stay stable until `int_ack`.
- R6: Data port accesses leave the pointer unchanged; there is no auto-increment.
- R7: Host address bits 1:0 are ignored. Offsets 0x60–0x63 all select the pointer, offsets 0x64–0x67 all select the data port, and every internal address has bits 1:0 zero.
- R8: Any other window offset performs the internal access at that offset with bits 1:0 cleared, and no base is added.
- R9: Pointer register accesses complete with `host_ack` one cycle after the request and issue no internal request.
- R10: The sum of pointer and base wraps modulo 2^19. With base 0x50000, pointer 0x30010 reaches internal address 0x00010.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Host access request, held until host_ack |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 8 | Byte offset inside the window |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, valid with host_ack on reads |
| host_ack | output | 1 | One-cycle completion pulse |
| host_wait | output | 1 | Access in progress on the internal bus |
| int_req | output | 1 | Internal request, held until int_ack |
| int_we | output | 1 | Internal write enable |
| int_addr | output | 19 | Internal byte address, longword aligned |
| int_wdata | output | 32 | Internal write data |
| int_rdata | input | 32 | Internal read data, valid with int_ack |
| int_ack | input | 1 | Internal acknowledge |

## Verification
The bench uses the default parameters: an 8-bit window, the pointer at 0x60, the data port at 0x64, a 19-bit internal space and base 0x50000. With that base, a pointer of 0x30010 carries past the top of the 512 KB space, so the wrap case can be tested. The internal responder's latency is changed between 0 and 3 idle cycles, which exercises both the single-cycle acknowledge and a longer stall. The misaligned host offsets used (0x63, 0x66, 0x13) fall in the pointer, data port and direct regions, so alignment is checked for each kind of target.

// File: rtl/ind_win_pkg.sv
package ind_win_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_BUSY, ST_DONE} seq_state_t;
  typedef enum logic [1:0] {TGT_PTR, TGT_DATA, TGT_DIRECT} target_t;
endpackage

// File: rtl/ind_win_decode.sv
module ind_win_decode
  import ind_win_pkg::*;
#(
  parameter int HOST_AW = 8,
  parameter logic [HOST_AW-1:0] PTR_OFS  = 8'h60,
  parameter logic [HOST_AW-1:0] DATA_OFS = 8'h64
) (
  input  logic [HOST_AW-3:0] word_idx,
  output target_t            tgt
);
  localparam logic [HOST_AW-3:0] PTR_WORD  = PTR_OFS[HOST_AW-1:2];
  localparam logic [HOST_AW-3:0] DATA_WORD = DATA_OFS[HOST_AW-1:2];

  always_comb begin
    if (word_idx == PTR_WORD)       tgt = TGT_PTR;
    else if (word_idx == DATA_WORD) tgt = TGT_DATA;
    else                            tgt = TGT_DIRECT;
  end
endmodule

// File: rtl/ind_win_ptr.sv
module ind_win_ptr #(
  parameter int IA_W = 19
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [IA_W-3:0] wr_word,
  output logic [IA_W-1:0] ptr
);
  logic [IA_W-3:0] word_q;

  always_ff @(posedge clk) begin
    if (rst)        word_q <= '0;
    else if (wr_en) word_q <= wr_word;
  end

  assign ptr = {word_q, 2'b00};

  // R6
  ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(ptr));
endmodule

// File: rtl/ind_win_seq.sv
module ind_win_seq
  import ind_win_pkg::*;
#(
  parameter int HOST_AW = 8,
  parameter int IA_W    = 19,
  parameter int DATA_W  = 32,
  parameter logic [IA_W-1:0] REG_BASE = 19'h50000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               host_req,
  input  logic               host_we,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [DATA_W-1:0]  host_wdata,
  input  target_t            tgt,
  input  logic [IA_W-1:0]    ptr,
  output logic               ptr_wr,
  output logic [DATA_W-1:0]  host_rdata,
  output logic               host_ack,
  output logic               host_wait,
  output logic               int_req,
  output logic               int_we,
  output logic [IA_W-1:0]    int_addr,
  output logic [DATA_W-1:0]  int_wdata,
  input  logic [DATA_W-1:0]  int_rdata,
  input  logic               int_ack
);
  localparam logic [IA_W-1:0] ALIGN_MASK = ~IA_W'(3);

  seq_state_t state;
  logic       start;

  assign start  = (state == ST_IDLE) && host_req;
  assign ptr_wr = start && host_we && (tgt == TGT_PTR);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      host_rdata <= '0;
      host_ack   <= 1'b0;
      host_wait  <= 1'b0;
      int_req    <= 1'b0;
      int_we     <= 1'b0;
      int_addr   <= '0;
      int_wdata  <= '0;
    end else begin
      host_ack <= 1'b0;
      case (state)
        ST_IDLE: if (host_req) begin
          if (tgt == TGT_PTR) begin
            host_rdata <= {{(DATA_W-IA_W){1'b0}}, ptr};
            host_ack   <= 1'b1;
            state      <= ST_DONE;
          end else begin
            int_req   <= 1'b1;
            int_we    <= host_we;
            int_wdata <= host_wdata;
            host_wait <= 1'b1;
            state     <= ST_BUSY;
            if (tgt == TGT_DATA) int_addr <= (ptr + REG_BASE) & ALIGN_MASK;
            else int_addr <= {{(IA_W-HOST_AW){1'b0}}, host_addr} & ALIGN_MASK;
          end
        end
        ST_BUSY: if (int_ack) begin
          int_req   <= 1'b0;
          host_wait <= 1'b0;
          host_ack  <= 1'b1;
          if (!int_we) host_rdata <= int_rdata;
          state     <= ST_DONE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R5
  int_hold_chk: assert property (@(posedge clk) disable iff (rst)
    int_req && !int_ack |=> int_req && $stable(int_addr) && $stable(int_we) && $stable(int_wdata));
  // R5
  wait_ack_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(host_wait && host_ack));
  // R4
  ack_follows_chk: assert property (@(posedge clk) disable iff (rst)
    int_req && int_ack |=> host_ack && !int_req);
  // R7
  int_align_chk: assert property (@(posedge clk) disable iff (rst)
    int_req |-> int_addr[1:0] == 2'b00);
  // R9
  ptr_local_chk: assert property (@(posedge clk) disable iff (rst)
    start && tgt == TGT_PTR |=> host_ack && !int_req);
  // R4
  ack_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    host_ack |=> !host_ack);
endmodule

// File: rtl/ind_win_bridge.sv
module ind_win_bridge
  import ind_win_pkg::*;
#(
  parameter int HOST_AW = 8,
  parameter int IA_W    = 19,
  parameter int DATA_W  = 32,
  parameter logic [HOST_AW-1:0] PTR_OFS  = 8'h60,
  parameter logic [HOST_AW-1:0] DATA_OFS = 8'h64,
  parameter logic [IA_W-1:0]    REG_BASE = 19'h50000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               host_req,
  input  logic               host_we,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [DATA_W-1:0]  host_wdata,
  output logic [DATA_W-1:0]  host_rdata,
  output logic               host_ack,
  output logic               host_wait,
  output logic               int_req,
  output logic               int_we,
  output logic [IA_W-1:0]    int_addr,
  output logic [DATA_W-1:0]  int_wdata,
  input  logic [DATA_W-1:0]  int_rdata,
  input  logic               int_ack
);
  target_t         tgt;
  logic            ptr_wr;
  logic [IA_W-1:0] ptr;

  ind_win_decode #(.HOST_AW(HOST_AW), .PTR_OFS(PTR_OFS), .DATA_OFS(DATA_OFS)) u_decode (
    .word_idx (host_addr[HOST_AW-1:2]),
    .tgt      (tgt)
  );

  ind_win_ptr #(.IA_W(IA_W)) u_ptr (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (ptr_wr),
    .wr_word (host_wdata[IA_W-1:2]),
    .ptr     (ptr)
  );

  ind_win_seq #(.HOST_AW(HOST_AW), .IA_W(IA_W), .DATA_W(DATA_W), .REG_BASE(REG_BASE)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .host_req   (host_req),
    .host_we    (host_we),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .tgt        (tgt),
    .ptr        (ptr),
    .ptr_wr     (ptr_wr),
    .host_rdata (host_rdata),
    .host_ack   (host_ack),
    .host_wait  (host_wait),
    .int_req    (int_req),
    .int_we     (int_we),
    .int_addr   (int_addr),
    .int_wdata  (int_wdata),
    .int_rdata  (int_rdata),
    .int_ack    (int_ack)
  );
endmodule

// File: tb/ind_win_bridge_tb.sv
module ind_win_bridge_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_req = 1'b0;
  logic        host_we = 1'b0;
  logic [7:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        host_ack, host_wait;
  logic        int_req, int_we;
  logic [18:0] int_addr;
  logic [31:0] int_wdata, int_rdata;
  logic        int_ack = 1'b0;

  int checks = 0;
  int errors = 0;
  int lat = 0;
  int lat_cnt = 0;
  int req_rises = 0;
  logic        req_prev = 1'b0;
  logic [18:0] seen_addr;
  logic        seen_we;
  logic [31:0] seen_wdata;
  logic [31:0] rd;
  int          waits;

  always #4 clk = ~clk;

  ind_win_bridge u_dut (
    .clk(clk), .rst(rst), .host_req(host_req), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_ack(host_ack), .host_wait(host_wait), .int_req(int_req),
    .int_we(int_we), .int_addr(int_addr), .int_wdata(int_wdata),
    .int_rdata(int_rdata), .int_ack(int_ack)
  );

  assign int_rdata = {13'h1A5, int_addr};

  always @(negedge clk) begin
    if (int_ack) begin
      int_ack <= 1'b0;
      lat_cnt <= 0;
    end else if (int_req) begin
      if (lat_cnt == lat) begin
        int_ack    <= 1'b1;
        seen_addr  <= int_addr;
        seen_we    <= int_we;
        seen_wdata <= int_wdata;
      end else lat_cnt <= lat_cnt + 1;
    end
  end

  always @(posedge clk) begin
    req_prev <= int_req;
    if (int_req && !req_prev) req_rises <= req_rises + 1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [7:0] a, input logic [31:0] d);
    int guard;
    @(negedge clk);
    host_req = 1'b1; host_we = we; host_addr = a; host_wdata = d;
    waits = 0; guard = 0;
    @(negedge clk);
    while (!host_ack && guard < 100) begin
      if (host_wait) waits++;
      guard++;
      @(negedge clk);
    end
    if (guard >= 100) check("watchdog", 32'd1, 32'd0);
    rd = host_rdata;
    host_req = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 host_ack", {31'b0, host_ack}, 32'd0);
    check("R1 host_wait", {31'b0, host_wait}, 32'd0);
    check("R1 int_req", {31'b0, int_req}, 32'd0);
    access(1'b0, 8'h60, '0);
    check("R1 pointer", rd, 32'd0);
  endtask

  task automatic t_ptr_rw();
    int r0;
    r0 = req_rises;
    access(1'b1, 8'h60, 32'hFFFF_FFFF);
    check("R9 write ack wait", waits, 0);
    access(1'b0, 8'h60, '0);
    check("R2 ptr readback", rd, 32'h0007_FFFC);
    check("R9 no internal req", req_rises - r0, 0);
  endtask

  task automatic t_data_write();
    lat = 2;
    access(1'b1, 8'h60, 32'h0000_0120);
    access(1'b1, 8'h64, 32'hDEAD_BEEF);
    check("R3 addr", {13'b0, seen_addr}, 32'h0005_0120);
    check("R3 we", {31'b0, seen_we}, 32'd1);
    check("R3 wdata", seen_wdata, 32'hDEAD_BEEF);
    check("R5 wait cycles", waits, 3);
  endtask

  task automatic t_data_read();
    lat = 3;
    access(1'b0, 8'h64, '0);
    check("R4 rdata", rd, {13'h1A5, 19'h50120});
    check("R5 wait cycles", waits, 4);
    access(1'b0, 8'h60, '0);
    check("R6 ptr unchanged", rd, 32'h0000_0120);
  endtask

  task automatic t_unaligned();
    lat = 0;
    access(1'b1, 8'h63, 32'h0000_0203);
    access(1'b0, 8'h61, '0);
    check("R7 ptr via 0x63", rd, 32'h0000_0200);
    access(1'b0, 8'h66, '0);
    check("R7 data via 0x66", {13'b0, seen_addr}, 32'h0005_0200);
    check("R5 wait lat0", waits, 1);
    access(1'b1, 8'h13, 32'h1234_5678);
    check("R7 direct aligned", {13'b0, seen_addr}, 32'h0000_0010);
  endtask

  task automatic t_direct();
    lat = 1;
    access(1'b0, 8'h40, '0);
    check("R8 direct addr", {13'b0, seen_addr}, 32'h0000_0040);
    check("R8 direct rdata", rd, {13'h1A5, 19'h00040});
  endtask

  task automatic t_wrap();
    lat = 0;
    access(1'b1, 8'h60, 32'h0003_0010);
    access(1'b1, 8'h64, 32'h0BAD_F00D);
    check("R10 wrap addr", {13'b0, seen_addr}, 32'h0000_0010);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_ptr_rw();
    t_data_write();
    t_data_read();
    t_unaligned();
    t_direct();
    t_wrap();
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule